// File: doc/BRIEF.md
# Broadcast Group Membership Filter

This block sits on the receive side of a node that listens to broadcast command packets. A packet reaches it as a byte stream on a valid/ready interface, with a start strobe on the first byte and an end strobe on the last. The node's own device number is a static configuration input. The filter answers one question per packet: does this command target this node? It answers with a one-cycle hit pulse or a one-cycle miss pulse, the cycle after the closing byte is accepted.

The lowest bit of the opening byte sets the packet's addressing form. In group form, the packet is a membership bitmap with one bit per device. The form bit takes stream bit 0, so the opening byte carries only seven device bits and every device's bit sits one place later than its number. In single form, the byte after the opening byte holds one device number, and only that device is addressed. The filter looks only at the one byte that can decide the outcome. It counts every other byte and ignores its contents, so it holds no packet storage.

The stream side never applies back-pressure. `in_ready` is low only while reset is asserted. After the first clock edge out of reset it stays high, so every beat with `in_valid` high is accepted in the cycle it is presented. A sender may drop `in_valid` between beats at any point, and beats with `in_valid` low have no effect.

Top module: `group_filter`

## Requirements
- R1: A beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is low during reset and high from the first clock edge after reset, and it never drops again. Beats with `in_valid` low have no effect on state or outputs.
- R2: A beat with `in_first` high is byte 0 of a packet. Bit 0 of byte 0 is the form flag: 0 selects group (bitmap) form and 1 selects single (direct ID) form.
- R3: In group form, device d owns stream bit position p = d + 1. Its bit is bit (p mod 8) of byte (p div 8), with bit 0 as the LSB. Byte 0 bits 7:1 therefore hold devices 0 to 6, and device 255 sits in bit 0 of byte 32, so a full bitmap is 33 bytes.
- R4: In group form, the packet is a hit exactly when the bit owned by `node_id` is 1.
- R5: In single form, byte 1 carries a device number and the packet is a hit exactly when it equals `node_id`. Bits 7:1 of byte 0 and all bytes after byte 1 are ignored.
- R6: If the packet ends before the byte that decides the outcome arrives (byte p div 8 in group form, byte 1 in single form), the result is a miss.
- R7: The contents of bytes other than the deciding byte never affect the result, however long the packet is.
- R8: Each accepted beat with `in_last` high inside a packet produces exactly one pulse, on `hit` or on `miss`, in the following cycle. Each pulse lasts one cycle. Neither output is ever high in any other cycle, and the two are never high together.
- R9: A beat with `in_first` high restarts the packet and discards any unfinished packet, even one that never saw `in_last`.
- R10: Beats accepted outside a packet (before any `in_first`, or after `in_last` and before the next `in_first`) are ignored and produce no pulse.
- R11: While `rst_n` is low, `hit` and `miss` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | 8 | This node's device number |
| in_valid | input | 1 | Stream byte is present |
| in_ready | output | 1 | Filter accepts the byte |
| in_data | input | 8 | Stream byte |
| in_first | input | 1 | Byte is byte 0 of a packet |
| in_last | input | 1 | Byte closes the packet |
| hit | output | 1 | One-cycle pulse: packet targets this node |
| miss | output | 1 | One-cycle pulse: packet does not target this node |

## Verification
The only results with latency are `hit` and `miss`. They are due one clock after the rising edge that accepts the closing byte, and they must be low in every other cycle. The bench drives each beat at a falling edge and lets one rising edge pass. At the next falling edge it compares both outputs and `in_ready` with a behavioural model that keeps the packet's bytes in a queue and works out the target byte with integer division. Idle cycles, stray beats and unfinished packets go through the same per-cycle comparison, so a pulse that is late, early or spurious shows up as a mismatch in the exact cycle it occurs.

// File: rtl/gf_pkg.sv
package gf_pkg;
  typedef enum logic {
    FORM_GROUP  = 1'b0,
    FORM_SINGLE = 1'b1
  } form_e;

  function automatic int map_bytes(input int id_w, input int byte_w);
    return ((1 << id_w) + 1 + byte_w - 1) / byte_w;
  endfunction
endpackage

// File: rtl/gf_beat_tracker.sv
module gf_beat_tracker
  import gf_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int MAP_BYTES = 33,
  parameter int IDX_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             first,
  input  logic             last,
  input  logic             flag_bit,
  output logic [IDX_W-1:0] cur_idx,
  output form_e            cur_form,
  output logic             take,
  output logic             end_now
);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(MAP_BYTES);

  logic [IDX_W-1:0] cnt_q;
  form_e            form_q;
  logic             active_q;

  assign cur_idx  = first ? '0 : cnt_q;
  assign cur_form = (cur_idx == '0) ? form_e'(flag_bit) : form_q;
  assign take     = beat && (first || active_q);
  assign end_now  = take && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      form_q   <= FORM_GROUP;
      active_q <= 1'b0;
    end else if (take) begin
      cnt_q    <= (cur_idx == IDX_MAX) ? IDX_MAX : cur_idx + 1'b1;
      form_q   <= cur_form;
      active_q <= !last;
    end
  end

  // R7: the byte index saturates and never passes the bitmap length
  assert_idx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= IDX_MAX);

  // R5: the addressing form stays put while a packet is idle between beats
  assert_form_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !beat) |=> $stable(form_q));
endmodule

// File: rtl/gf_bit_probe.sv
module gf_bit_probe
  import gf_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 6
) (
  input  logic [ID_W-1:0]   node_id,
  input  logic [IDX_W-1:0]  cur_idx,
  input  form_e             cur_form,
  input  logic [BYTE_W-1:0] data,
  output logic              beat_hit
);
  localparam int LANE_W = $clog2(BYTE_W);
  localparam int POS_W  = ID_W + 1;

  logic [POS_W-1:0]  pos;
  logic [LANE_W-1:0] lane;
  logic              group_sel;
  logic              single_eq;
  logic              group_hit;
  logic              single_hit;

  assign pos       = {1'b0, node_id} + 1'b1;
  assign lane      = pos[LANE_W-1:0];
  assign group_sel = (int'(cur_idx) == int'(pos >> LANE_W));

  generate
    if (ID_W == BYTE_W) begin : g_full
      assign single_eq = (data == node_id);
    end else begin : g_part
      assign single_eq = (data[ID_W-1:0] == node_id) && (data[BYTE_W-1:ID_W] == '0);
    end
  endgenerate

  assign group_hit  = group_sel && data[lane];
  assign single_hit = (cur_idx == IDX_W'(1)) && single_eq;
  assign beat_hit   = (cur_form == FORM_SINGLE) ? single_hit : group_hit;
endmodule

// File: rtl/gf_verdict.sv
module gf_verdict (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic first,
  input  logic end_now,
  input  logic beat_hit,
  output logic hit,
  output logic miss
);
  logic acc_q;
  logic acc_new;

  assign acc_new = (first ? 1'b0 : acc_q) | beat_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      hit   <= 1'b0;
      miss  <= 1'b0;
    end else begin
      if (take) acc_q <= acc_new;
      hit  <= end_now && acc_new;
      miss <= end_now && !acc_new;
    end
  end

  // R8: never both outcomes at once
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && miss));

  // R8: a closing beat is always answered on the next cycle
  assert_due_R8: assert property (@(posedge clk) disable iff (!rst_n)
    end_now |=> (hit || miss));

  // R8: no answer without a closing beat one cycle earlier
  assert_only_after_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit || miss) |-> $past(end_now));
endmodule

// File: rtl/group_filter.sv
module group_filter
  import gf_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   node_id,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_first,
  input  logic              in_last,
  output logic              hit,
  output logic              miss
);
  localparam int MAP_BYTES = map_bytes(ID_W, BYTE_W);
  localparam int IDX_W     = $clog2(MAP_BYTES + 1);

  logic             rdy_q;
  logic             beat;
  logic [IDX_W-1:0] cur_idx;
  form_e            cur_form;
  logic             take;
  logic             end_now;
  logic             beat_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign in_ready = rdy_q;
  assign beat     = in_valid && rdy_q;

  gf_beat_tracker #(
    .BYTE_W(BYTE_W), .MAP_BYTES(MAP_BYTES), .IDX_W(IDX_W)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .beat(beat), .first(in_first), .last(in_last),
    .flag_bit(in_data[0]), .cur_idx(cur_idx), .cur_form(cur_form),
    .take(take), .end_now(end_now)
  );

  gf_bit_probe #(
    .ID_W(ID_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W)
  ) u_probe (
    .node_id(node_id), .cur_idx(cur_idx), .cur_form(cur_form),
    .data(in_data), .beat_hit(beat_hit)
  );

  gf_verdict u_verdict (
    .clk(clk), .rst_n(rst_n), .take(take), .first(in_first),
    .end_now(end_now), .beat_hit(beat_hit), .hit(hit), .miss(miss)
  );

  // R1: once the stream side is ready it stays ready
  assert_ready_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);
endmodule

// File: tb/group_filter_test.sv
`timescale 1ns/1ps
module group_filter_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] node_id;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic       in_first;
  logic       in_last;
  logic       hit;
  logic       miss;

  always #2.5 clk = ~clk;

  group_filter uut (
    .clk(clk), .rst_n(rst_n), .node_id(node_id), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_first(in_first),
    .in_last(in_last), .hit(hit), .miss(miss)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] pkt[$];
  bit  m_active = 0;
  bit  exp_hit  = 0;
  bit  exp_miss = 0;

  function automatic bit model_eval();
    int pos, b;
    if (pkt.size() == 0) return 0;
    if (pkt[0][0]) return (pkt.size() >= 2) && (pkt[1] == node_id);
    pos = int'(node_id) + 1;
    b   = pos / 8;
    if (pkt.size() <= b) return 0;
    return pkt[b][pos % 8];
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Entered at a falling edge; leaves at the next falling edge after comparing.
  task automatic step(bit v, bit f, bit l, logic [7:0] d, string tag);
    in_valid = v; in_first = f; in_last = l; in_data = d;
    exp_hit = 0; exp_miss = 0;
    if (v) begin
      if (f) begin pkt.delete(); m_active = 1; end
      if (m_active) begin
        pkt.push_back(d);
        if (l) begin
          exp_hit  = model_eval();
          exp_miss = !exp_hit;
          m_active = 0;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, {hit, miss}, {exp_hit, exp_miss}, "hit/miss");
    check("R1", {1'b0, in_ready}, 2'b01, "in_ready");
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, $urandom_range(0, 1), $urandom_range(0, 1), 8'($urandom), tag);
  endtask

  task automatic send(logic [7:0] bytes[$], string tag, bit gaps);
    for (int i = 0; i < bytes.size(); i++) begin
      if (gaps && ($urandom_range(0, 3) == 0)) idle($urandom_range(1, 2), "R1");
      step(1, i == 0, i == bytes.size() - 1, bytes[i], tag);
    end
  endtask

  task automatic group_pkt(int id, bit set_bit, bit fill, int len, string tag);
    logic [7:0] q[$];
    int pos = id + 1;
    for (int i = 0; i < len; i++) q.push_back(fill ? 8'hFF : 8'h00);
    q[0][0] = 1'b0;
    if ((pos / 8) < len) q[pos / 8][pos % 8] = set_bit;
    send(q, tag, 0);
  endtask

  task automatic run_all();
    logic [7:0] q[$];
    rst_n = 0; node_id = 8'd0; in_valid = 0; in_first = 0; in_last = 0; in_data = 0;
    repeat (3) @(negedge clk);
    check("R11", {hit, miss}, 2'b00, "outputs in reset");
    check("R1", {1'b0, in_ready}, 2'b00, "in_ready in reset");
    rst_n = 1;
    @(negedge clk);

    // R3 / R4: group form at several positions
    node_id = 8'd0;   group_pkt(0, 1, 0, 1, "R4");
    node_id = 8'd0;   group_pkt(0, 0, 1, 1, "R4");
    node_id = 8'd6;   group_pkt(6, 1, 0, 2, "R3");
    node_id = 8'd7;   group_pkt(7, 1, 0, 2, "R3");
    node_id = 8'd7;   group_pkt(7, 0, 1, 3, "R3");
    node_id = 8'd255; group_pkt(255, 1, 0, 33, "R3");
    node_id = 8'd255; group_pkt(255, 0, 1, 33, "R4");
    // R7: deciding bit alone decides, other bytes full or empty, long packet
    node_id = 8'd100; group_pkt(100, 0, 1, 40, "R7");
    node_id = 8'd100; group_pkt(100, 1, 0, 40, "R7");
    // R6: packet too short for the deciding byte
    node_id = 8'd100; group_pkt(100, 1, 1, 12, "R6");
    idle(2, "R10");

    // R5: single form
    node_id = 8'd42;
    q = '{8'h01, 8'd42};        send(q, "R5", 0);
    q = '{8'hFF, 8'd42};        send(q, "R5", 1);
    q = '{8'h01, 8'd43};        send(q, "R5", 0);
    q = '{8'h01, 8'd43, 8'd42}; send(q, "R5", 0);
    q = '{8'h01};               send(q, "R6", 0);

    // R9: unfinished packet discarded by a fresh start
    step(1, 1, 0, 8'h01, "R9"); step(1, 0, 0, 8'd42, "R9");
    q = '{8'h00, 8'h00};        send(q, "R9", 0);
    step(1, 1, 0, 8'h00, "R9"); step(1, 0, 0, 8'h00, "R9");
    q = '{8'h01, 8'd42};        send(q, "R9", 0);

    // R10: stray beats after a packet, including a stray closing beat
    step(1, 0, 0, 8'd42, "R10");
    step(1, 0, 1, 8'd42, "R10");
    step(0, 1, 1, 8'h01, "R10");

    // R8: back-to-back one-byte packets
    node_id = 8'd3;
    q = '{8'h10}; send(q, "R8", 0);
    q = '{8'h00}; send(q, "R8", 0);
    q = '{8'h10}; send(q, "R8", 0);

    // R2 / R4: mixed random packets with gaps
    for (int n = 0; n < 300; n++) begin
      int len = $urandom_range(1, 40);
      node_id = 8'($urandom);
      q.delete();
      for (int i = 0; i < len; i++) q.push_back(8'($urandom));
      if ($urandom_range(0, 1)) begin
        int pos = int'(node_id) + 1;
        if ((pos / 8) < len) q[pos / 8][pos % 8] = 1'b1;
      end
      if (q[0][0] && len > 1 && $urandom_range(0, 1)) q[1] = node_id;
      send(q, "R2", 1);
      if ($urandom_range(0, 4) == 0) idle(1, "R10");
    end
    idle(3, "R8");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule